// File: doc/BRIEF.md
# Charger Protection Fault Sequencer

This block is the digital control core of a safety switch that sits between a charger supply and a battery. It receives five digitized comparator flags: supply-present (power-on-reset released), supply overvoltage, battery overvoltage, overcurrent and over-temperature. From these it drives the enable of the series pass switch, a request for the gate driver to ramp the switch on slowly, and an active-low fault indication.

Once the supply is present, the sequencer waits through a settling delay and then ramps the switch on. Each fault has its own response. Supply overvoltage and over-temperature act directly, without filtering. Battery overvoltage and overcurrent must persist through their own blanking windows before they count. Every confirmed battery-overvoltage or overcurrent event is counted, and reaching the configured count latches the switch off until the supply goes away and returns. When a non-latching fault clears, the switch rests for a short off interval and is then brought back through the soft-start ramp.

All durations are parameters in clock cycles. The comparator flags are asynchronous and pass through two-stage synchronizers inside the block.

Top module: `chg_guard_seq`

## Requirements
- R1: While `rst` is high or the synchronized supply-present flag is low, `sw_en` and `ramp_req` are 0 and `fault_n` is 1.
- R2: When supply-present rises, the switch stays off for SETTLE_CYC cycles, then `sw_en` and `ramp_req` are both 1 for RAMP_CYC cycles, after which `ramp_req` drops and `sw_en` stays 1. Every rise of `sw_en` coincides with `ramp_req` being 1.
- R3: Supply overvoltage is not filtered: `sw_en` falls on the third clock edge after `vin_hi_in` rises, and `fault_n` is 0 while the flag stays high.
- R4: After a non-latching fault clears, the switch stays off for OFF_CYC cycles and then re-enters the soft-start ramp.
- R5: If supply overvoltage is present when the settling delay ends, the switch is never enabled while the flag persists. The switch is enabled after the flag clears.
- R6: A battery-overvoltage pulse shorter than BOVP_BLANK_CYC cycles has no effect on `sw_en` or `fault_n`.
- R7: A battery-overvoltage flag held for BOVP_BLANK_CYC cycles turns the switch off and pulls `fault_n` low. `sw_en` falls on the edge BOVP_BLANK_CYC+3 cycles after the flag rises.
- R8: The BOVP_LIMIT-th confirmed battery-overvoltage event latches the switch off. `sw_en` stays 0 and `fault_n` stays 0 after the flag clears.
- R9: An overcurrent pulse shorter than OCP_BLANK_CYC cycles is ignored. A longer one turns the switch off, and the switch then restarts through soft-start.
- R10: The OCP_LIMIT-th confirmed overcurrent event latches the switch off permanently.
- R11: Over-temperature turns the switch off and holds `fault_n` low while the flag is high. The switch restarts through soft-start once the flag falls.
- R12: A low period on supply-present clears both event counts and the latch. Afterwards a single confirmed event no longer latches.
- R13: A latch-off takes priority over any restart. A latched block never re-enters soft-start while the supply stays present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_ok_in | input | 1 | Asynchronous flag, 1 = supply above power-on threshold |
| vin_hi_in | input | 1 | Asynchronous flag, 1 = supply overvoltage |
| bat_hi_in | input | 1 | Asynchronous flag, 1 = battery overvoltage |
| cur_hi_in | input | 1 | Asynchronous flag, 1 = overcurrent |
| temp_hi_in | input | 1 | Asynchronous hysteretic flag, 1 = over-temperature |
| sw_en | output | 1 | Pass-switch enable, high during ramp and when fully on |
| ramp_req | output | 1 | Soft-start ramp request |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The hardest state to reach from the ports is the permanent latch-off. It exists only after the last of a long series of confirmed events, and each of those events must pass its blanking window and then be followed by a complete recovery. The stimulus therefore drives each event as a full cycle: the flag is held past blanking, dropped, and the bench waits through the off interval and the ramp. It confirms the switch is fully on again after every event below the limit. At the limit it then shows that the latch survives the flag clearing and yields only to a supply-present drop.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    ST_DOWN   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_OFF    = 3'd2,
    ST_RAMP   = 3'd3,
    ST_ON     = 3'd4,
    ST_LATCH  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cps_blank.sv
// Persistence filter: the flag must stay high BLANK consecutive cycles.
module cps_blank #(
  parameter int BLANK = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic flag,
  output logic held,
  output logic hit
);
  localparam int CW = $clog2(BLANK + 1);
  localparam logic [CW-1:0] FULL = CW'(BLANK);
  localparam logic [CW-1:0] PRE  = CW'(BLANK - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !flag) begin
      cnt <= '0;
      hit <= 1'b0;
    end else begin
      if (cnt != FULL) cnt <= cnt + 1'b1;
      hit <= (cnt == PRE);
    end
  end

  assign held = (cnt == FULL);
endmodule

// File: rtl/cps_evcount.sv
// Counts confirmed events; trip stays high once LIMIT is reached.
module cps_evcount #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic trip
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (hit && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign trip = (cnt == TOP);
endmodule

// File: rtl/chg_guard_seq.sv
module chg_guard_seq
  import cps_pkg::*;
#(
  parameter int SETTLE_CYC     = 1250000,
  parameter int RAMP_CYC       = 125000,
  parameter int OFF_CYC        = 12500,
  parameter int BOVP_BLANK_CYC = 22500,
  parameter int OCP_BLANK_CYC  = 21250,
  parameter int BOVP_LIMIT     = 16,
  parameter int OCP_LIMIT      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic por_ok_in,
  input  logic vin_hi_in,
  input  logic bat_hi_in,
  input  logic cur_hi_in,
  input  logic temp_hi_in,
  output logic sw_en,
  output logic ramp_req,
  output logic fault_n
);
  localparam int NFLAG = 5;
  localparam int MAX_A = (SETTLE_CYC > RAMP_CYC) ? SETTLE_CYC : RAMP_CYC;
  localparam int MAX_T = (MAX_A > OFF_CYC) ? MAX_A : OFF_CYC;
  localparam int TW    = $clog2(MAX_T + 1);
  localparam logic [TW-1:0] SETTLE_END = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] RAMP_END   = TW'(RAMP_CYC - 1);
  localparam logic [TW-1:0] OFF_END    = TW'(OFF_CYC - 1);
  localparam logic [TW-1:0] TSAT       = '1;

  logic [NFLAG-1:0] sync_q;
  logic por_s, vin_s, bat_s, cur_s, otp_s;

  cps_sync #(.W(NFLAG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({temp_hi_in, cur_hi_in, bat_hi_in, vin_hi_in, por_ok_in}),
    .q   (sync_q)
  );

  assign por_s = sync_q[0];
  assign vin_s = sync_q[1];
  assign bat_s = sync_q[2];
  assign cur_s = sync_q[3];
  assign otp_s = sync_q[4];

  logic bat_held, bat_hit, cur_held, cur_hit;
  logic bat_trip, cur_trip;

  cps_blank #(.BLANK(BOVP_BLANK_CYC)) u_bat_blank (
    .clk(clk), .rst(rst), .flag(bat_s), .held(bat_held), .hit(bat_hit)
  );

  cps_blank #(.BLANK(OCP_BLANK_CYC)) u_cur_blank (
    .clk(clk), .rst(rst), .flag(cur_s), .held(cur_held), .hit(cur_hit)
  );

  cps_evcount #(.LIMIT(BOVP_LIMIT)) u_bat_cnt (
    .clk(clk), .rst(rst), .clr(!por_s), .hit(bat_hit), .trip(bat_trip)
  );

  cps_evcount #(.LIMIT(OCP_LIMIT)) u_cur_cnt (
    .clk(clk), .rst(rst), .clr(!por_s), .hit(cur_hit), .trip(cur_trip)
  );

  logic fault_any, trip_any;
  assign fault_any = vin_s | otp_s | bat_held | cur_held;
  assign trip_any  = bat_trip | cur_trip;

  seq_state_t state, nxt;
  logic [TW-1:0] tmr;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_DOWN:   nxt = ST_SETTLE;
      ST_SETTLE: if (tmr == SETTLE_END) nxt = fault_any ? ST_OFF : ST_RAMP;
      ST_OFF:    if (!fault_any && tmr == OFF_END) nxt = ST_RAMP;
      ST_RAMP: begin
        if (fault_any)            nxt = ST_OFF;
        else if (tmr == RAMP_END) nxt = ST_ON;
      end
      ST_ON:     if (fault_any) nxt = ST_OFF;
      ST_LATCH:  nxt = ST_LATCH;
      default:   nxt = ST_DOWN;
    endcase
    if (trip_any) nxt = ST_LATCH;
    if (!por_s)   nxt = ST_DOWN;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_DOWN;
    else     state <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || nxt != state || (state == ST_OFF && fault_any)) tmr <= '0;
    else if (tmr != TSAT) tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_en    <= 1'b0;
      ramp_req <= 1'b0;
      fault_n  <= 1'b1;
    end else begin
      sw_en    <= (nxt == ST_RAMP) || (nxt == ST_ON);
      ramp_req <= (nxt == ST_RAMP);
      fault_n  <= !((nxt == ST_LATCH) || (por_s && fault_any));
    end
  end
endmodule

// File: rtl/cps_seq_chk.sv
module cps_seq_chk
  import cps_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       por_s,
  input logic       vin_s,
  input logic       otp_s,
  input seq_state_t state,
  input logic       sw_en,
  input logic       ramp_req,
  input logic       fault_n
);
  // R1
  down_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !por_s |=> (!sw_en && !ramp_req && fault_n));

  // R2
  ramp_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en) |-> ramp_req);

  // R3
  vin_cut_chk: assert property (@(posedge clk) disable iff (rst)
    vin_s |=> (!sw_en && !ramp_req));

  // R11
  otp_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (otp_s && por_s) |=> (!sw_en && !fault_n));

  // R13
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LATCH && por_s) |=> (state == ST_LATCH && !sw_en && !fault_n));
endmodule

bind chg_guard_seq cps_seq_chk u_chk (.*);

// File: tb/chg_guard_seq_test.sv
module chg_guard_seq_test;
  localparam int S  = 20;
  localparam int R  = 8;
  localparam int W  = 4;
  localparam int BB = 12;
  localparam int OB = 10;
  localparam int BL = 16;
  localparam int OL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic por_ok_in = 1'b0, vin_hi_in = 1'b0, bat_hi_in = 1'b0;
  logic cur_hi_in = 1'b0, temp_hi_in = 1'b0;
  logic sw_en, ramp_req, fault_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chg_guard_seq #(
    .SETTLE_CYC(S), .RAMP_CYC(R), .OFF_CYC(W),
    .BOVP_BLANK_CYC(BB), .OCP_BLANK_CYC(OB),
    .BOVP_LIMIT(BL), .OCP_LIMIT(OL)
  ) uut (.*);

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // expected {sw_en, ramp_req, fault_n}
  task automatic chk(string req, logic [2:0] exp);
    checks++;
    if ({sw_en, ramp_req, fault_n} !== exp) begin
      fails++;
      $display("FAIL %s: {sw,ramp,fault_n} actual %b expected %b at %0t",
               req, {sw_en, ramp_req, fault_n}, exp, $time);
    end
  endtask

  task automatic power_up(string req);
    por_ok_in = 1'b1;
    step(2 + S);     chk(req, 3'b001);
    step(1);         chk(req, 3'b111);
    step(R - 1);     chk(req, 3'b111);
    step(1);         chk(req, 3'b101);
  endtask

  task automatic power_cycle();
    por_ok_in = 1'b0;
    step(4);        chk("R1", 3'b001);
    power_up("R12");
  endtask

  task automatic t_reset();
    step(3);        chk("R1", 3'b001);
    rst = 1'b0;
    step(5);        chk("R1", 3'b001);
  endtask

  task automatic t_vin();
    vin_hi_in = 1'b1;
    step(2);        chk("R3", 3'b101);
    step(1);        chk("R3", 3'b000);
    step(10);       chk("R3", 3'b000);
    vin_hi_in = 1'b0;
    step(1 + W);    chk("R4", 3'b001);
    step(1);        chk("R4", 3'b111);
    step(R);        chk("R4", 3'b101);
  endtask

  task automatic t_vin_early();
    por_ok_in = 1'b0;
    step(4);
    vin_hi_in = 1'b1;
    por_ok_in = 1'b1;
    step(S + R + 20); chk("R5", 3'b000);
    vin_hi_in = 1'b0;
    step(W + R + 6);  chk("R5", 3'b101);
  endtask

  task automatic t_otp();
    temp_hi_in = 1'b1;
    step(3);        chk("R11", 3'b000);
    step(15);       chk("R11", 3'b000);
    temp_hi_in = 1'b0;
    step(2 + W);    chk("R11", 3'b111);
    step(R + 2);    chk("R11", 3'b101);
  endtask

  task automatic t_bat_short();
    bat_hi_in = 1'b1;
    step(BB - 1);
    bat_hi_in = 1'b0;
    for (int i = 0; i < BB + 6; i++) begin
      if (sw_en !== 1'b1 || fault_n !== 1'b1) begin
        chk("R6", 3'b101);
        break;
      end
      step(1);
    end
    chk("R6", 3'b101);
  endtask

  task automatic bat_event(bit check_edge);
    bat_hi_in = 1'b1;
    if (check_edge) begin
      step(BB + 2); chk("R7", 3'b101);
      step(1);      chk("R7", 3'b000);
      step(1);
    end else begin
      step(BB + 4);
    end
    bat_hi_in = 1'b0;
    step(W + R + 8);
  endtask

  task automatic t_bat_latch();
    bat_event(1'b1);
    chk("R7", 3'b101);
    for (int i = 1; i < BL - 1; i++) bat_event(1'b0);
    chk("R8", 3'b101);
    bat_event(1'b0);
    chk("R8", 3'b000);
    step(S + R + 40); chk("R13", 3'b000);
  endtask

  task automatic cur_event();
    cur_hi_in = 1'b1;
    step(OB + 4);
    cur_hi_in = 1'b0;
    step(W + R + 8);
  endtask

  task automatic t_cur();
    cur_hi_in = 1'b1;
    step(OB - 1);
    cur_hi_in = 1'b0;
    step(OB + 6);   chk("R9", 3'b101);
    cur_hi_in = 1'b1;
    step(OB + 3);   chk("R9", 3'b000);
    cur_hi_in = 1'b0;
    step(W + R + 8); chk("R9", 3'b101);
    for (int i = 1; i < OL - 1; i++) cur_event();
    chk("R10", 3'b101);
    cur_event();
    chk("R10", 3'b000);
    step(40);       chk("R13", 3'b000);
  endtask

  task automatic t_after_clear();
    bat_event(1'b0);
    chk("R12", 3'b101);
  endtask

  initial begin
    t_reset();
    power_up("R2");
    t_vin();
    t_vin_early();
    t_otp();
    t_bat_short();
    t_bat_latch();
    power_cycle();
    t_after_clear();
    t_cur();
    power_cycle();
    t_after_clear();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule